// File: doc/BRIEF.md
# Reset Control Configuration Register Bank

This block is a small byte-wide configuration register bank spanning indices 44h through 4Bh. Software writes it to pulse or hold the IDE and PCI bus resets, to request a system-wide warm reset, and to set a group of enable bits for five function spaces and two I/O base-address decoders. A read of the control register also reports whether a warm start has taken place since power-up.

Access is a single-cycle write strobe with an index and a data byte. Read data is combinational from the index. An active-low power-on reset returns every register to its default. A warm reset request produces a fixed-length pulse on the system reset output. The pulse returns the registers to their defaults but keeps the warm-start history. The IDE reset output comes with its own output enable. It stays undriven after power-on and after a warm start until software first asserts it.

Top module: `rstcfg_bank`

## Requirements
- R1: After power-on reset, index 44h reads 01h, 46h reads FEh and 47h reads 00h. The outputs are sys_rst=0, ide_rst_n=1, ide_rst_oe=0, pci_rst_n=1, fn_en=1Fh, lpc_dec_en=0 and gpio_dec_en=0.
- R2: Writing 44h with bit 2 set drives ide_rst_n low from the next cycle and sets ide_rst_oe. Writing bit 2 as 0 returns ide_rst_n high while ide_rst_oe stays 1. Bit 2 reads back what was written.
- R3: ide_rst_oe stays 0 after power-on or warm reset until a write to 44h with bit 2 set. Writes with bit 2 clear do not enable it.
- R4: Bit 1 of 44h is level-sensitive. While it holds 1, pci_rst_n is low. Changing it leaves every other output unchanged.
- R5: A write to 44h with bit 0 set raises sys_rst from the next cycle for exactly PULSE_LEN (default 16) cycles. A write with bit 0 clear never raises sys_rst.
- R6: Bit 0 of 44h reads 1 until a warm reset has been requested and 0 afterwards, including during the pulse. Only power-on reset returns it to 1.
- R7: A warm reset request clears the IDE and PCI reset bits, turns off ide_rst_oe and restores 46h and 47h to their defaults, in the same edge that starts the pulse. Writes that arrive while sys_rst is high are ignored.
- R8: At 46h, bits 5:1 are writable and drive fn_en[4:0]. Bits 7:6 always read 11 and bit 0 always reads 0.
- R9: At 47h, bit 2 drives lpc_dec_en and bit 1 drives gpio_dec_en. Bits 7:3 and 0 always read 0.
- R10: Indices 45h, 48h to 4Bh and every index outside 44h to 4Bh read 00h. Writes to them change no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data for cfg_idx |
| ide_rst_n | output | 1 | Active-low IDE bus reset |
| ide_rst_oe | output | 1 | Output enable for ide_rst_n; 0 means high impedance |
| pci_rst_n | output | 1 | Active-low PCI bus reset |
| sys_rst | output | 1 | Active-high warm reset pulse |
| fn_en | output | 5 | Enables for function spaces 5 to 1 (bit 4 = space 5) |
| lpc_dec_en | output | 1 | LPC base-address decode enable |
| gpio_dec_en | output | 1 | GPIO base-address decode enable |

## Verification
Read data depends only on the index and the registers, so it is due in the same cycle the index is presented. Register and output effects of a write appear one edge after the strobe is sampled. The warm reset pulse is high from the first edge after the write through the sixteenth. Every driver task changes inputs just after a rising edge and queues its expected item. The monitor compares outputs and read data at the following falling edge, so each comparison lands in the cycle the requirement names. During a pulse, the bench checks the system reset output once per cycle for sixteen cycles and then once more to confirm it has dropped.

// File: rtl/rstcfg_bank.sv
module rstcfg_bank #(
  parameter int IDX_W     = 8,
  parameter int PULSE_LEN = 16,
  parameter logic [IDX_W-1:0] CTRL_IDX = IDX_W'('h44),
  parameter logic [IDX_W-1:0] FEN_IDX  = IDX_W'('h46),
  parameter logic [IDX_W-1:0] MEN_IDX  = IDX_W'('h47)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  output logic             ide_rst_n,
  output logic             ide_rst_oe,
  output logic             pci_rst_n,
  output logic             sys_rst,
  output logic [4:0]       fn_en,
  output logic             lpc_dec_en,
  output logic             gpio_dec_en
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] pulse_cnt;
  logic          ide_bit, pci_bit, oe_q, warm_seen;
  logic [4:0]    fen_q;
  logic [1:0]    men_q;

  wire open_wr = cfg_wr && !sys_rst;
  wire wr_ctl  = open_wr && (cfg_idx == CTRL_IDX);
  wire wr_fen  = open_wr && (cfg_idx == FEN_IDX);
  wire wr_men  = open_wr && (cfg_idx == MEN_IDX);
  wire warm_go = wr_ctl && cfg_wdata[0];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pulse_cnt <= '0;
      ide_bit   <= 1'b0;
      pci_bit   <= 1'b0;
      oe_q      <= 1'b0;
      warm_seen <= 1'b0;
      fen_q     <= 5'h1f;
      men_q     <= 2'b00;
    end else if (warm_go) begin
      pulse_cnt <= CW'(PULSE_LEN);
      ide_bit   <= 1'b0;
      pci_bit   <= 1'b0;
      oe_q      <= 1'b0;
      warm_seen <= 1'b1;
      fen_q     <= 5'h1f;
      men_q     <= 2'b00;
    end else begin
      if (pulse_cnt != '0) pulse_cnt <= pulse_cnt - 1'b1;
      if (wr_ctl) begin
        ide_bit <= cfg_wdata[2];
        pci_bit <= cfg_wdata[1];
        if (cfg_wdata[2]) oe_q <= 1'b1;
      end
      if (wr_fen) fen_q <= cfg_wdata[5:1];
      if (wr_men) men_q <= cfg_wdata[2:1];
    end
  end

  assign sys_rst     = (pulse_cnt != '0);
  assign ide_rst_n   = !ide_bit;
  assign ide_rst_oe  = oe_q;
  assign pci_rst_n   = !pci_bit;
  assign fn_en       = fen_q;
  assign lpc_dec_en  = men_q[1];
  assign gpio_dec_en = men_q[0];

  always_comb begin
    cfg_rdata = 8'h00;
    if (cfg_idx == CTRL_IDX)     cfg_rdata = {5'b0, ide_bit, pci_bit, !warm_seen};
    else if (cfg_idx == FEN_IDX) cfg_rdata = {2'b11, fen_q, 1'b0};
    else if (cfg_idx == MEN_IDX) cfg_rdata = {5'b0, men_q, 1'b0};
  end
endmodule

// File: rtl/rstcfg_bank_chk.sv
module rstcfg_bank_chk #(
  parameter int IDX_W     = 8,
  parameter int PULSE_LEN = 16,
  parameter logic [IDX_W-1:0] CTRL_IDX = IDX_W'('h44),
  parameter logic [IDX_W-1:0] FEN_IDX  = IDX_W'('h46),
  parameter logic [IDX_W-1:0] MEN_IDX  = IDX_W'('h47)
) (
  input logic             clk,
  input logic             por_n,
  input logic             cfg_wr,
  input logic [IDX_W-1:0] cfg_idx,
  input logic [7:0]       cfg_wdata,
  input logic [7:0]       cfg_rdata,
  input logic             ide_rst_n,
  input logic             ide_rst_oe,
  input logic             pci_rst_n,
  input logic             sys_rst,
  input logic [4:0]       fn_en,
  input logic             lpc_dec_en,
  input logic             gpio_dec_en
);
  localparam int RW = $clog2(PULSE_LEN + 2) + 1;
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) run <= '0;
    else        run <= sys_rst ? run + 1'b1 : '0;
  end

  a_r2_low_needs_drive: assert property (@(posedge clk) disable iff (!por_n)
    !ide_rst_n |-> ide_rst_oe);

  a_r3_oe_only_by_write: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ide_rst_oe) |-> $past(cfg_wr && cfg_idx == CTRL_IDX && cfg_wdata[2]));

  a_r5_trigger: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_wr && cfg_idx == CTRL_IDX && cfg_wdata[0] && !sys_rst) |=> sys_rst);

  a_r5_pulse_len: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> (run == RW'(PULSE_LEN)));

  a_r5_no_overrun: assert property (@(posedge clk) disable iff (!por_n)
    run <= RW'(PULSE_LEN));

  a_r6_flag_low_in_pulse: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && cfg_idx == CTRL_IDX) |-> !cfg_rdata[0]);

  a_r7_defaults_in_pulse: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |-> (ide_rst_n && pci_rst_n && !ide_rst_oe && fn_en == 5'h1f
                 && !lpc_dec_en && !gpio_dec_en));

  a_r8_fixed_bits: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_idx == FEN_IDX) |-> (cfg_rdata[7:6] == 2'b11 && !cfg_rdata[0]));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_idx != CTRL_IDX && cfg_idx != FEN_IDX && cfg_idx != MEN_IDX) |-> (cfg_rdata == 8'h00));
endmodule

bind rstcfg_bank rstcfg_bank_chk #(
  .IDX_W(IDX_W), .PULSE_LEN(PULSE_LEN),
  .CTRL_IDX(CTRL_IDX), .FEN_IDX(FEN_IDX), .MEN_IDX(MEN_IDX)
) u_chk (
  .clk(clk), .por_n(por_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ide_rst_n(ide_rst_n),
  .ide_rst_oe(ide_rst_oe), .pci_rst_n(pci_rst_n), .sys_rst(sys_rst),
  .fn_en(fn_en), .lpc_dec_en(lpc_dec_en), .gpio_dec_en(gpio_dec_en)
);

// File: tb/tb_rstcfg_bank.sv
module tb_rstcfg_bank;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_idx = 8'h00;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       ide_rst_n, ide_rst_oe, pci_rst_n, sys_rst, lpc_dec_en, gpio_dec_en;
  logic [4:0] fn_en;

  always #5 clk = ~clk;

  rstcfg_bank dut (
    .clk(clk), .por_n(por_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ide_rst_n(ide_rst_n),
    .ide_rst_oe(ide_rst_oe), .pci_rst_n(pci_rst_n), .sys_rst(sys_rst),
    .fn_en(fn_en), .lpc_dec_en(lpc_dec_en), .gpio_dec_en(gpio_dec_en)
  );

  typedef struct {
    logic [7:0]  rd;
    logic [10:0] outs;
    string       tag;
  } item_t;

  item_t sb[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // shadow of the requirements
  bit m_ide, m_pci, m_oe, m_warm, m_sys;
  logic [4:0] m_fn;
  bit m_lpc, m_gpio;

  function automatic logic [10:0] exp_outs();
    return {m_sys, !m_ide, m_oe, !m_pci, m_fn, m_lpc, m_gpio};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h44:   return {5'b0, m_ide, m_pci, !m_warm};
      8'h46:   return {2'b11, m_fn, 1'b0};
      8'h47:   return {5'b0, m_lpc, m_gpio, 1'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_defaults();
    m_ide = 0; m_pci = 0; m_oe = 0; m_sys = 0;
    m_fn = 5'h1f; m_lpc = 0; m_gpio = 0;
  endtask

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [10:0] got;
      it = sb.pop_front();
      got = {sys_rst, ide_rst_n, ide_rst_oe, pci_rst_n, fn_en, lpc_dec_en, gpio_dec_en};
      n_vec++;
      if (got !== it.outs || cfg_rdata !== it.rd) begin
        n_bad++;
        $display("FAIL %s idx=%h: outs=%b rdata=%h expected outs=%b rdata=%h",
                 it.tag, cfg_idx, got, cfg_rdata, it.outs, it.rd);
      end
    end
  end

  task automatic chk(input logic [7:0] a, input string tag);
    item_t it;
    cfg_idx = a;
    it.rd = exp_rd(a);
    it.outs = exp_outs();
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic chk_state(input string tag);
    chk(8'h44, tag);
    chk(8'h46, tag);
    chk(8'h47, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfg_idx = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic do_por();
    por_n = 1'b0;
    model_defaults();
    m_warm = 0;
    @(posedge clk); #1;
    chk(8'h44, "R1 during reset");
    por_n = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL watchdog: expired at cycle %0d, expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    do_por();
    chk_state("R1");

    // R3: clear bit 2 does not enable the IDE driver
    wr(8'h44, 8'h00);
    chk(8'h44, "R3");
    // R4: PCI reset only
    wr(8'h44, 8'h02); m_pci = 1;
    chk_state("R4");
    // R2: IDE reset asserted and driven
    wr(8'h44, 8'h04); m_pci = 0; m_ide = 1; m_oe = 1;
    chk_state("R2");
    wr(8'h44, 8'h00); m_ide = 0;
    chk(8'h44, "R2 release keeps oe");
    // R4: PCI toggles leave IDE drive alone
    wr(8'h44, 8'h06); m_ide = 1; m_pci = 1;
    chk(8'h44, "R4");
    wr(8'h44, 8'h04); m_pci = 0;
    chk(8'h44, "R4");

    // R8
    wr(8'h46, 8'h00); m_fn = 5'h00;
    chk(8'h46, "R8");
    wr(8'h46, 8'hff); m_fn = 5'h1f;
    chk(8'h46, "R8");
    wr(8'h46, 8'h14); m_fn = 5'h0a;
    chk(8'h46, "R8");

    // R9
    wr(8'h47, 8'hff); m_lpc = 1; m_gpio = 1;
    chk(8'h47, "R9");
    wr(8'h47, 8'h02); m_lpc = 0; m_gpio = 1;
    chk(8'h47, "R9");

    // R10: reserved and unmapped indices
    for (int i = 0; i < 6; i++) begin
      logic [7:0] a;
      a = (i == 0) ? 8'h45 : (i == 5) ? 8'h80 : 8'(8'h47 + i);
      wr(a, 8'hff);
      chk(a, "R10");
    end
    chk_state("R10 state unchanged");

    // R5: writing 0 to bit 0 has no effect
    wr(8'h44, 8'h06); m_ide = 1; m_pci = 1;
    chk(8'h44, "R5 no pulse on bit0=0");

    // R5/R6/R7: warm reset pulse
    wr(8'h44, 8'h01);
    model_defaults(); m_warm = 1; m_sys = 1;
    for (int i = 0; i < 16; i++) chk(8'h44, "R5 R6 R7 pulse");
    m_sys = 0;
    chk(8'h44, "R5 pulse end");
    chk_state("R7 after warm");

    // R3 after warm: driver stays off until bit 2 written
    wr(8'h44, 8'h02); m_pci = 1;
    chk(8'h44, "R3 after warm");
    wr(8'h44, 8'h04); m_pci = 0; m_ide = 1; m_oe = 1;
    chk(8'h44, "R6 flag survives, R2");

    // R7: writes during the pulse are ignored
    wr(8'h47, 8'h04); m_lpc = 1;
    wr(8'h44, 8'h01);
    wr(8'h46, 8'h00);
    wr(8'h47, 8'h06);
    wr(8'h44, 8'h04);
    repeat (20) begin @(posedge clk); #1; end
    model_defaults();
    chk_state("R7 writes in pulse ignored");

    // R6: only power-on reset restores the flag
    do_por();
    chk(8'h44, "R6 POR restores flag");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule